// File: doc/BRIEF.md
# MSI Capability and Interrupt Message Generator

This block is the device-side end of message-signalled interrupts. It holds the MSI capability structure in configuration space, behind a small register read/write port, and converts per-vector event pulses from the device into posted memory-write requests. Each request carries the address that software programmed and a 16-bit data word. The low bits of that data word are replaced by the number of the vector that fired.

Software sets how many vectors are enabled as a power of two, and the block keeps only events whose vector falls inside that range. When per-vector masking is built in, an event on a masked vector is held as a pending bit. It is released as a message once software clears the mask bit. Several events that arrive together are queued and issued lowest vector first, one request per accepted valid/ready handshake. While MSI is enabled, the block tells the rest of the device to stop legacy wire-style interrupt signalling.

Top module: `msi_cap_gen`

## Requirements
- R1: After reset, the dword at byte offset 00h reads ID 05h in bits 7:0, the NEXT_PTR parameter in bits 15:8, and the control word in bits 31:16. The control word has enable at bit 0, the capable log2 count at bits 3:1, the enabled log2 count at bits 6:4, the 64-bit flag at bit 7 and the masking flag at bit 8; both enable fields read zero. After reset, `req_valid_o` and `intx_disable_o` are low.
- R2: Control bit 0 (write data bit 16 at offset 00h) is read/write, and `intx_disable_o` equals its stored value.
- R3: Control bits 6:4 (write data bits 22:20) store the enabled log2 count, and a value above the capable count is stored as the capable count. Writes to bits 3:1, 7 and 8 have no effect.
- R4: With the 64-bit layout, offset 04h holds the lower address with bits 1:0 reading zero, 08h holds the upper address, and 0Ch holds the 16-bit data with bits 31:16 reading zero.
- R5: An accepted, unmasked event drives `req_valid_o` high after the next rising edge. The request carries address {upper, lower}, and `req_wide_o` is 1 exactly when the upper address is nonzero.
- R6: With enabled log2 count m, `req_data_o` equals the programmed data with its low m bits replaced by the vector index.
- R7: An event on a vector at or above 2^m produces no request and sets no pending bit.
- R8: An event on a vector whose mask bit (offset 10h, bit v) is set sends nothing and sets pending bit v (offset 14h, bit v). Clearing that mask bit issues the message one edge later and clears the pending bit.
- R9: Writes to the pending register at 14h have no effect.
- R10: While enable is 0, events produce no request and set no pending bit.
- R11: Events on several vectors, whether they arrive together or while the output is stalled, are all issued in ascending vector order, one per handshake.
- R12: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its address, data and wide flag stay unchanged.
- R13: Clearing a mask bit while enable is 0 discards that vector's pending bit, and no message follows later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset (dword aligned) |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for cfg_addr_i |
| evt_i | input | 32 | Per-vector event pulses |
| intx_disable_o | output | 1 | High while MSI is enabled |
| req_valid_o | output | 1 | Write request valid |
| req_ready_i | input | 1 | Write request accepted |
| req_addr_o | output | 64 | Write request address |
| req_data_o | output | 16 | Write request data |
| req_wide_o | output | 1 | Request needs a 64-bit address |

## Verification
The hardest case to reach is a mask clear that has to release a held event. The pending bit must be set first, under a mask. The release must then be seen in the single cycle after the mask write, and it must not be confused with a message that was already queued. The bench masks one vector, fires it, and reads the pending register back, including after a write to that register. It then clears the mask and samples the request one edge later. A variant runs the same steps with enable low. Stall ordering is covered by holding ready low while a second event arrives behind a queued burst. Randomised bursts with random ready gaps then cover every enabled-count setting.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam logic [7:0] MSI_CAP_ID   = 8'h05;
    localparam logic [7:0] OFS_HDR      = 8'h00;
    localparam logic [7:0] OFS_ADDR_LO  = 8'h04;
    localparam logic [7:0] OFS_ADDR_HI  = 8'h08;

    typedef struct packed {
        logic       en;
        logic [2:0] mme;
    } msi_ctl_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [15:0] data;
        logic        wide;
    } msi_req_t;

    // Replace the low mme bits of base with the vector index.
    function automatic logic [15:0] insert_vector(input logic [15:0] base,
                                                  input logic [2:0]  mme,
                                                  input logic [15:0] vec);
        logic [15:0] keep;
        keep = (16'h1 << mme) - 16'h1;
        return (base & ~keep) | (vec & keep);
    endfunction

    function automatic logic [15:0] ctrl_word(input msi_ctl_t c,
                                              input logic [2:0] mmc,
                                              input logic cap64,
                                              input logic pvm);
        return {7'b0, pvm, cap64, c.mme, mmc, c.en};
    endfunction

endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int         VEC_LOG2_CAP = 5,
    parameter bit         CAP64        = 1'b1,
    parameter bit         PVM          = 1'b1,
    parameter logic [7:0] NEXT_PTR     = 8'h70
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_wr,
    input  logic [7:0]                        cfg_addr,
    input  logic [31:0]                       cfg_wdata,
    input  logic [(1<<VEC_LOG2_CAP)-1:0]      pend_q,
    output msi_ctl_t                          ctl,
    output logic [31:0]                       addr_lo,
    output logic [31:0]                       addr_hi,
    output logic [15:0]                       data,
    output logic [(1<<VEC_LOG2_CAP)-1:0]      mask_q,
    output logic [(1<<VEC_LOG2_CAP)-1:0]      mask_nxt,
    output logic [31:0]                       rdata
);
    localparam int         VEC_CNT  = 1 << VEC_LOG2_CAP;
    localparam logic [2:0] MMC      = 3'(VEC_LOG2_CAP);
    localparam logic [7:0] OFS_DATA = CAP64 ? 8'h0C : 8'h08;
    localparam logic [7:0] OFS_MASK = OFS_DATA + 8'h04;
    localparam logic [7:0] OFS_PEND = OFS_DATA + 8'h08;

    logic [7:0] wa;
    logic       wr_hdr, wr_lo, wr_hi, wr_data, wr_mask;
    logic [2:0] mme_req;

    assign wa      = {cfg_addr[7:2], 2'b00};
    assign wr_hdr  = cfg_wr && (wa == OFS_HDR);
    assign wr_lo   = cfg_wr && (wa == OFS_ADDR_LO);
    assign wr_hi   = cfg_wr && CAP64 && (wa == OFS_ADDR_HI);
    assign wr_data = cfg_wr && (wa == OFS_DATA);
    assign wr_mask = cfg_wr && PVM && (wa == OFS_MASK);
    assign mme_req = (cfg_wdata[22:20] > MMC) ? MMC : cfg_wdata[22:20];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            addr_lo <= '0;
            addr_hi <= '0;
            data    <= '0;
        end else begin
            if (wr_hdr) begin
                ctl.en  <= cfg_wdata[16];
                ctl.mme <= mme_req;
            end
            if (wr_lo)   addr_lo <= {cfg_wdata[31:2], 2'b00};
            if (wr_hi)   addr_hi <= cfg_wdata;
            if (wr_data) data    <= cfg_wdata[15:0];
        end
    end

    generate
        if (PVM) begin : g_mask
            logic [VEC_CNT-1:0] mask_r;
            always_ff @(posedge clk) begin
                if (rst) mask_r <= '0;
                else     mask_r <= mask_nxt;
            end
            assign mask_q   = mask_r;
            assign mask_nxt = wr_mask ? cfg_wdata[VEC_CNT-1:0] : mask_r;
        end else begin : g_nomask
            assign mask_q   = '0;
            assign mask_nxt = '0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (wa == OFS_HDR)
            rdata = {ctrl_word(ctl, MMC, CAP64, PVM), NEXT_PTR, MSI_CAP_ID};
        else if (wa == OFS_ADDR_LO)
            rdata = addr_lo;
        else if (CAP64 && (wa == OFS_ADDR_HI))
            rdata = addr_hi;
        else if (wa == OFS_DATA)
            rdata = {16'h0, data};
        else if (PVM && (wa == OFS_MASK))
            rdata = 32'(mask_q);
        else if (PVM && (wa == OFS_PEND))
            rdata = 32'(pend_q);
    end

    // R3
    mme_in_cap_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.mme <= MMC);

    // R4
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        addr_lo[1:0] == 2'b00);

endmodule

// File: rtl/msi_vec_sched.sv
module msi_vec_sched #(
    parameter int VEC_LOG2_CAP = 5
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [(1<<VEC_LOG2_CAP)-1:0]                   evt,
    input  logic                                           en,
    input  logic [2:0]                                     mme,
    input  logic [(1<<VEC_LOG2_CAP)-1:0]                   mask_nxt,
    input  logic                                           out_free,
    output logic [(1<<VEC_LOG2_CAP)-1:0]                   pend_q,
    output logic                                           ld,
    output logic [((VEC_LOG2_CAP>0)?VEC_LOG2_CAP:1)-1:0]   ld_vec
);
    localparam int VEC_CNT = 1 << VEC_LOG2_CAP;
    localparam int VW      = (VEC_LOG2_CAP > 0) ? VEC_LOG2_CAP : 1;

    logic [VEC_CNT-1:0] in_rng, accept, send, pend_d, queue_q, queue_d, cand, pick;

    generate
        for (genvar v = 0; v < VEC_CNT; v++) begin : g_rng
            assign in_rng[v] = ((32'(v) >> mme) == 32'd0);
        end
    endgenerate

    always_comb begin
        accept  = en ? (evt & in_rng) : '0;
        send    = en ? ((accept | pend_q) & ~mask_nxt) : '0;
        pend_d  = en ? ((pend_q | accept) & mask_nxt) : (pend_q & mask_nxt);
        cand    = en ? (queue_q | send) : '0;
        pick    = cand & (~cand + 1'b1);
        ld      = out_free && (cand != '0);
        queue_d = ld ? (cand & ~pick) : cand;
        ld_vec  = '0;
        for (int v = 0; v < VEC_CNT; v++)
            if (pick[v]) ld_vec = VW'(v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            queue_q <= '0;
        end else begin
            pend_q  <= pend_d;
            queue_q <= queue_d;
        end
    end

    // R7
    load_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        ld |-> ((32'(ld_vec) >> mme) == 32'd0));

    // R10
    no_pend_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
    import msi_cap_pkg::*;
#(
    parameter int VEC_LOG2_CAP = 5,
    parameter bit CAP64        = 1'b1
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           ld,
    input  logic [((VEC_LOG2_CAP>0)?VEC_LOG2_CAP:1)-1:0]   ld_vec,
    input  logic [2:0]                                     mme,
    input  logic [31:0]                                    addr_lo,
    input  logic [31:0]                                    addr_hi,
    input  logic [15:0]                                    data,
    input  logic                                           req_ready,
    output logic                                           req_valid,
    output msi_req_t                                       req,
    output logic                                           out_free
);
    logic [31:0] hi_eff;
    msi_req_t    nxt;

    assign hi_eff   = CAP64 ? addr_hi : 32'h0;
    assign out_free = !req_valid || req_ready;

    always_comb begin
        nxt.addr = {hi_eff, addr_lo};
        nxt.data = insert_vector(data, mme, 16'(ld_vec));
        nxt.wide = (hi_eff != 32'h0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req       <= '0;
        end else if (ld) begin
            req_valid <= 1'b1;
            req       <= nxt;
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end

    // R12
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req.addr)
                                       && $stable(req.data) && $stable(req.wide)));

    // R5
    wide_flag_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req.wide == (req.addr[63:32] != 32'h0)));

endmodule

// File: rtl/msi_cap_gen.sv
module msi_cap_gen
    import msi_cap_pkg::*;
#(
    parameter int         VEC_LOG2_CAP = 5,
    parameter bit         CAP64        = 1'b1,
    parameter bit         PVM          = 1'b1,
    parameter logic [7:0] NEXT_PTR     = 8'h70
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_wr_i,
    input  logic [7:0]                        cfg_addr_i,
    input  logic [31:0]                       cfg_wdata_i,
    output logic [31:0]                       cfg_rdata_o,
    input  logic [(1<<VEC_LOG2_CAP)-1:0]      evt_i,
    output logic                              intx_disable_o,
    output logic                              req_valid_o,
    input  logic                              req_ready_i,
    output logic [63:0]                       req_addr_o,
    output logic [15:0]                       req_data_o,
    output logic                              req_wide_o
);
    localparam int VEC_CNT = 1 << VEC_LOG2_CAP;
    localparam int VW      = (VEC_LOG2_CAP > 0) ? VEC_LOG2_CAP : 1;

    msi_ctl_t           ctl;
    logic [31:0]        addr_lo, addr_hi;
    logic [15:0]        data;
    logic [VEC_CNT-1:0] mask_q, mask_nxt, pend_q;
    logic               ld, out_free;
    logic [VW-1:0]      ld_vec;
    msi_req_t           req;

    msi_cap_regs #(
        .VEC_LOG2_CAP(VEC_LOG2_CAP), .CAP64(CAP64), .PVM(PVM), .NEXT_PTR(NEXT_PTR)
    ) regs_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr_i), .cfg_addr(cfg_addr_i),
        .cfg_wdata(cfg_wdata_i), .pend_q(pend_q), .ctl(ctl), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .data(data), .mask_q(mask_q), .mask_nxt(mask_nxt),
        .rdata(cfg_rdata_o)
    );

    msi_vec_sched #(.VEC_LOG2_CAP(VEC_LOG2_CAP)) sched_i (
        .clk(clk), .rst(rst), .evt(evt_i), .en(ctl.en), .mme(ctl.mme),
        .mask_nxt(mask_nxt), .out_free(out_free), .pend_q(pend_q),
        .ld(ld), .ld_vec(ld_vec)
    );

    msi_msg_out #(.VEC_LOG2_CAP(VEC_LOG2_CAP), .CAP64(CAP64)) out_i (
        .clk(clk), .rst(rst), .ld(ld), .ld_vec(ld_vec), .mme(ctl.mme),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data),
        .req_ready(req_ready_i), .req_valid(req_valid_o), .req(req),
        .out_free(out_free)
    );

    assign intx_disable_o = ctl.en;
    assign req_addr_o     = req.addr;
    assign req_data_o     = req.data;
    assign req_wide_o     = req.wide;

    // R8
    pend_only_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~mask_q) == '0);

endmodule

// File: tb/msi_cap_gen_tb.sv
module msi_cap_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] evt = '0;
    logic        intx_dis;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [63:0] req_addr;
    logic [15:0] req_data;
    logic        req_wide;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    msi_cap_gen dut_i (
        .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .evt_i(evt),
        .intx_disable_o(intx_dis), .req_valid_o(req_valid), .req_ready_i(req_ready),
        .req_addr_o(req_addr), .req_data_o(req_data), .req_wide_o(req_wide)
    );

    function automatic logic [15:0] exp_data(input logic [15:0] base, input int m, input int v);
        logic [15:0] low;
        low = 16'((32'd1 << m) - 1);
        return (base & ~low) | (16'(v) & low);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] lo, hi;
        logic [15:0] base;
        int seq[4];
        void'($urandom(32'd1234));

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(8'h00, r);
        check("R1 header", r, 32'h018A_7005);
        check("R1 idle valid", req_valid, 0);
        check("R1 intx", intx_dis, 0);

        // R2 R3 all-ones write: enable set, MME clamped to 5, caps unchanged
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r);
        check("R3 ctrl clamp", r, 32'h01DB_7005);
        check("R2 intx on", intx_dis, 1);

        // R4 register layout
        wr(8'h04, 32'h1234_5677);
        wr(8'h08, 32'h0000_00AB);
        wr(8'h0C, 32'hFFFF_ABC0);
        rd(8'h04, r); check("R4 addr lo", r, 32'h1234_5674);
        rd(8'h08, r); check("R4 addr hi", r, 32'h0000_00AB);
        rd(8'h0C, r); check("R4 data", r, 32'h0000_ABC0);

        // R5 R6 single event, m=2
        wr(8'h00, 32'h0021_0000);
        req_ready = 1'b1;
        pulse(32'h8);
        check("R5 valid", req_valid, 1);
        check("R5 addr", req_addr, 64'h0000_00AB_1234_5674);
        check("R5 wide", req_wide, 1);
        check("R6 data", req_data, 16'hABC3);
        @(negedge clk);
        check("R5 one write", req_valid, 0);

        // R7 out of range vector 4 with N=4
        pulse(32'h10);
        check("R7 no req", req_valid, 0);
        repeat (2) @(negedge clk);
        check("R7 still none", req_valid, 0);
        rd(8'h14, r); check("R7 no pend", r, 0);

        // R8 R9 masking and pending
        wr(8'h10, 32'h2);
        pulse(32'h2);
        check("R8 masked none", req_valid, 0);
        rd(8'h14, r); check("R8 pend set", r, 32'h2);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, r); check("R9 pend ro", r, 32'h2);
        wr(8'h10, 32'h0);
        check("R8 release valid", req_valid, 1);
        check("R8 release data", req_data, 16'hABC1);
        rd(8'h14, r); check("R8 pend clr", r, 0);
        @(negedge clk);

        // R11 R12 burst under stall, plus a late event
        req_ready = 1'b0;
        pulse(32'hD);
        check("R11 first", req_data, 16'hABC0);
        pulse(32'h2);
        repeat (2) @(negedge clk);
        check("R12 held valid", req_valid, 1);
        check("R12 held data", req_data, 16'hABC0);
        seq = '{0, 1, 2, 3};
        req_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check("R11 order valid", req_valid, 1);
            check("R11 order", req_data, exp_data(16'hABC0, 2, seq[i]));
            @(negedge clk);
        end
        check("R11 drained", req_valid, 0);

        // R10 disabled drops events
        wr(8'h00, 32'h0020_0000);
        check("R2 intx off", intx_dis, 0);
        wr(8'h10, 32'h4);
        pulse(32'h5);
        check("R10 no req", req_valid, 0);
        rd(8'h14, r); check("R10 no pend", r, 0);

        // R13 unmask while disabled discards
        wr(8'h00, 32'h0021_0000);
        pulse(32'h4);
        rd(8'h14, r); check("R13 pend pre", r, 32'h4);
        wr(8'h00, 32'h0020_0000);
        wr(8'h10, 32'h0);
        rd(8'h14, r); check("R13 pend gone", r, 0);
        wr(8'h00, 32'h0021_0000);
        repeat (2) @(negedge clk);
        check("R13 no req", req_valid, 0);

        // R5 R6 R7 R11 random bursts with random stalls
        for (int b = 0; b < 60; b++) begin
            int m;
            logic [31:0] e, keep, rem;
            int guard;
            m    = $urandom % 6;
            lo   = $urandom & 32'hFFFF_FFFC;
            hi   = ($urandom % 2) ? $urandom : 32'h0;
            base = 16'($urandom);
            wr(8'h00, 32'h0001_0000 | (32'(m) << 20));
            wr(8'h04, lo);
            wr(8'h08, hi);
            wr(8'h0C, {16'h0, base});
            keep = 32'((64'd1 << (1 << m)) - 1);
            e    = $urandom;
            if ((e & keep) == 0) e = e | 32'h1;
            rem  = e & keep;
            @(negedge clk);
            evt = e;
            guard = 0;
            while (rem != 0 && guard < 300) begin
                @(negedge clk);
                evt = '0;
                req_ready = ($urandom % 4) != 0;
                guard++;
                #1;
                if (req_valid && req_ready) begin
                    int v;
                    v = 0;
                    for (int k = 31; k >= 0; k--) if (rem[k]) v = k;
                    check("R11 rnd data", req_data, exp_data(base, m, v));
                    check("R5 rnd addr", req_addr, {hi, lo});
                    check("R5 rnd wide", req_wide, hi != 0);
                    rem[v] = 1'b0;
                end
            end
            check("R11 rnd complete", rem, 0);
            @(negedge clk);
            check("R7 rnd no extra", req_valid, 0);
            req_ready = 1'b1;
        end

        finish_run();
    end

endmodule